// File: doc/BRIEF.md
# Dual-Source Interrupt Request and Vector Unit

This unit raises and serves interrupt requests on behalf of a peripheral module that contains two serial channels. Source A is the queued synchronous channel and source B is the asynchronous channel. Each source has its own programmable request level. A source whose request input is high and whose level is non-zero asserts the matching line of a seven-line request bus. The line stays asserted until the peripheral drops its request input.

When the processor acknowledges a level, it supplies a 3-bit priority mask. The unit contends only if a pending source sits at the acknowledged level, that level is above the mask (level 7 cannot be masked), and the arbitration ID is non-zero. The unit then shifts its 4-bit arbitration ID onto a shared wired-OR contention line, most significant bit first. If it is still in the contest after the last bit, it drives an 8-bit vector number for one cycle together with a valid strobe.

Both sources share one vector register. Bit 0 of the vector is never stored: it reads as 1, and in a delivered vector it identifies the source.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset the registers read as follows: the vector register reads 0x0F, both level fields read 0, and the arbitration ID reads 0. In the same state no request line is asserted, the contention output is low, and the vector strobe is low.
- R2: Register offsets are 0 for levels, 1 for the vector and 2 for the ID. Offset 0 holds source A's level in bits [6:4] and source B's level in bits [2:0], with bits 7 and 3 reading 0. Offset 2 holds the ID in bits [3:0], with the upper bits reading 0.
- R3: A write to the vector register stores bits [7:1]. Bit 0 of a write is ignored, and reads of the vector register return 1 in bit 0.
- R4: `irq_lines[n-1]` is high in the same cycle as long as either source has request high and level n (n = 1 to 7). A source at level 0 asserts no line.
- R5: An acknowledge starts contention only when all of these hold:
  - a source with request high has level equal to `iack_level`;
  - that level is greater than `iack_mask`, or equals 7;
  - the ID is non-zero.
  If any condition fails, `arb_drive` and `vec_valid` stay low.
- R6: An ID of zero never drives the contention line or the vector, so the acknowledge goes unanswered.
- R7: While contending, the unit drives ID bit 3 in the first cycle after the acknowledge is sampled, then bits 2, 1 and 0 in the three following cycles.
- R8: In a cycle where the unit drives 0 but `arb_line` reads 1, it withdraws. It drives nothing further and gives no vector.
- R9: A unit that stays in the contest through all four bits raises `vec_valid` for exactly one cycle, in the fifth cycle after the acknowledge is sampled. In that cycle `vec_data` is vector bits [7:1] followed by 1 for source A or 0 for source B.
- R10: If both sources are pending at the acknowledged level, source A is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| req_a | input | 1 | Request from the synchronous channel |
| req_b | input | 1 | Request from the asynchronous channel |
| irq_lines | output | 7 | Request bus, bit n-1 is level n |
| iack | input | 1 | Acknowledge strobe, one cycle |
| iack_level | input | 3 | Level being acknowledged |
| iack_mask | input | 3 | Processor priority mask |
| arb_drive | output | 1 | This unit's bit onto the wired-OR contention line |
| arb_line | input | 1 | Resolved contention line |
| vec_valid | output | 1 | Vector strobe |
| vec_data | output | 8 | Vector number |

## Verification
Register reads and the request bus are combinational, so they are sampled on the falling edge that follows the write or the change of request. Contention bits are due one to four cycles after the rising edge that takes `iack`, and the vector is due in the fifth.

The bench samples on the falling edge of each of those cycles. In each cycle it compares `arb_drive` with the expected ID bit, and it applies its rival's bit to the line in that same half-cycle. It also checks `vec_valid` in all six cycles after every acknowledge, which confirms the strobe is a single cycle and that withdrawal suppresses it.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] ADDR_LEVELS = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_VECTOR = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_ARBID  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CONTEND = 2'd1,
    ST_DELIVER = 2'd2
  } arb_state_t;
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs
  import irqv_pkg::*;
#(
  parameter int LVL_W   = 3,
  parameter int ID_W    = 4,
  parameter int DATA_W  = 8,
  parameter logic [DATA_W-1:0] VEC_RESET = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [LVL_W-1:0]  lvl_a,
  output logic [LVL_W-1:0]  lvl_b,
  output logic [DATA_W-2:0] vec_hi,
  output logic [ID_W-1:0]   arb_id
);
  localparam int HALF = DATA_W / 2;

  logic [LVL_W-1:0]  lvl_a_q, lvl_a_d;
  logic [LVL_W-1:0]  lvl_b_q, lvl_b_d;
  logic [DATA_W-2:0] vec_q, vec_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic              en_lvl, en_vec, en_id;

  always_comb begin
    en_lvl  = reg_we && (reg_addr == ADDR_LEVELS);
    en_vec  = reg_we && (reg_addr == ADDR_VECTOR);
    en_id   = reg_we && (reg_addr == ADDR_ARBID);
    lvl_a_d = reg_wdata[HALF +: LVL_W];
    lvl_b_d = reg_wdata[0 +: LVL_W];
    vec_d   = reg_wdata[DATA_W-1:1];
    id_d    = reg_wdata[ID_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_a_q <= '0;
      lvl_b_q <= '0;
      vec_q   <= VEC_RESET[DATA_W-1:1];
      id_q    <= '0;
    end else begin
      if (en_lvl) begin
        lvl_a_q <= lvl_a_d;
        lvl_b_q <= lvl_b_d;
      end
      if (en_vec) vec_q <= vec_d;
      if (en_id)  id_q  <= id_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_LEVELS: begin
        reg_rdata[HALF +: LVL_W] = lvl_a_q;
        reg_rdata[0 +: LVL_W]    = lvl_b_q;
      end
      ADDR_VECTOR: reg_rdata = {vec_q, 1'b1};
      ADDR_ARBID:  reg_rdata[ID_W-1:0] = id_q;
      default:     reg_rdata = '0;
    endcase
  end

  assign lvl_a  = lvl_a_q;
  assign lvl_b  = lvl_b_q;
  assign vec_hi = vec_q;
  assign arb_id = id_q;
endmodule

// File: rtl/irqv_req_map.sv
module irqv_req_map #(
  parameter int LVL_W  = 3,
  parameter int NLINES = (1 << LVL_W) - 1
) (
  input  logic              req_a,
  input  logic              req_b,
  input  logic [LVL_W-1:0]  lvl_a,
  input  logic [LVL_W-1:0]  lvl_b,
  input  logic [LVL_W-1:0]  ack_level,
  input  logic [LVL_W-1:0]  ack_mask,
  output logic [NLINES-1:0] irq_lines,
  output logic              hit,
  output logic              hit_src_a
);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NLINES);

  logic on_a, on_b, at_a, at_b, unmasked;

  always_comb begin
    on_a = req_a && (lvl_a != '0);
    on_b = req_b && (lvl_b != '0);
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    localparam logic [LVL_W-1:0] LINE_LVL = LVL_W'(i + 1);
    assign irq_lines[i] = (on_a && (lvl_a == LINE_LVL)) ||
                          (on_b && (lvl_b == LINE_LVL));
  end

  always_comb begin
    at_a      = on_a && (lvl_a == ack_level);
    at_b      = on_b && (lvl_b == ack_level);
    unmasked  = (ack_level == TOP_LVL) || (ack_level > ack_mask);
    hit       = (at_a || at_b) && unmasked;
    hit_src_a = at_a;
  end
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iack,
  input  logic              hit,
  input  logic              hit_src_a,
  input  logic [ID_W-1:0]   arb_id,
  input  logic [DATA_W-2:0] vec_hi,
  input  logic              arb_line,
  output logic              arb_drive,
  output logic              vec_valid,
  output logic [DATA_W-1:0] vec_data,
  output logic              busy
);
  localparam int IDX_W = (ID_W > 1) ? $clog2(ID_W) : 1;
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(ID_W - 1);

  arb_state_t       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic             src_q, src_d;
  logic             my_bit, lost;

  always_comb begin
    my_bit = (st_q == ST_CONTEND) ? id_q[idx_q] : 1'b0;
    lost   = (st_q == ST_CONTEND) && !my_bit && arb_line;
    st_d   = st_q;
    idx_d  = idx_q;
    id_d   = id_q;
    src_d  = src_q;
    case (st_q)
      ST_IDLE: begin
        if (iack && hit && (arb_id != '0)) begin
          st_d  = ST_CONTEND;
          idx_d = IDX_TOP;
          id_d  = arb_id;
          src_d = hit_src_a;
        end
      end
      ST_CONTEND: begin
        if (lost) begin
          st_d = ST_IDLE;
        end else if (idx_q == '0) begin
          st_d = ST_DELIVER;
        end else begin
          idx_d = idx_q - 1'b1;
        end
      end
      ST_DELIVER: st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      id_q  <= '0;
      src_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      id_q  <= id_d;
      src_q <= src_d;
    end
  end

  always_comb begin
    arb_drive = my_bit;
    vec_valid = (st_q == ST_DELIVER);
    vec_data  = vec_valid ? {vec_hi, src_q} : '0;
    busy      = (st_q != ST_IDLE);
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irqv_pkg::*;
#(
  parameter int LVL_W  = 3,
  parameter int ID_W   = 4,
  parameter int DATA_W = 8,
  localparam int NLINES = (1 << LVL_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              req_a,
  input  logic              req_b,
  output logic [NLINES-1:0] irq_lines,
  input  logic              iack,
  input  logic [LVL_W-1:0]  iack_level,
  input  logic [LVL_W-1:0]  iack_mask,
  output logic              arb_drive,
  input  logic              arb_line,
  output logic              vec_valid,
  output logic [DATA_W-1:0] vec_data
);
  logic [LVL_W-1:0]  lvl_a, lvl_b;
  logic [DATA_W-2:0] vec_hi;
  logic [ID_W-1:0]   arb_id;
  logic              hit, hit_src_a, arb_busy;

  irqv_regs #(.LVL_W(LVL_W), .ID_W(ID_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lvl_a(lvl_a),
    .lvl_b(lvl_b), .vec_hi(vec_hi), .arb_id(arb_id)
  );

  irqv_req_map #(.LVL_W(LVL_W), .NLINES(NLINES)) u_map (
    .req_a(req_a), .req_b(req_b), .lvl_a(lvl_a), .lvl_b(lvl_b),
    .ack_level(iack_level), .ack_mask(iack_mask), .irq_lines(irq_lines),
    .hit(hit), .hit_src_a(hit_src_a)
  );

  irqv_arbiter #(.ID_W(ID_W), .DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .iack(iack), .hit(hit),
    .hit_src_a(hit_src_a), .arb_id(arb_id), .vec_hi(vec_hi),
    .arb_line(arb_line), .arb_drive(arb_drive), .vec_valid(vec_valid),
    .vec_data(vec_data), .busy(arb_busy)
  );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 8,
  parameter int NLINES = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_a,
  input logic              req_b,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NLINES-1:0] irq_lines,
  input logic              arb_drive,
  input logic              arb_line,
  input logic              vec_valid,
  input logic [DATA_W-1:0] vec_data,
  input logic              arb_busy,
  input logic              iack,
  input logic [ID_W-1:0]   arb_id,
  input logic [DATA_W-2:0] vec_hi
);
  a_r3_bit0_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> reg_rdata[0]);

  a_r4_quiet_without_request: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_a && !req_b) |-> (irq_lines == '0));

  a_r4_at_most_two_lines: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_lines) <= 2);

  a_r6_zero_id_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_busy && (arb_id == '0)) |=> !arb_drive && !vec_valid);

  a_r8_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_busy && !vec_valid && !arb_drive && arb_line) |=> !arb_busy);

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  a_r9_vector_upper: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_data[DATA_W-1:1] == vec_hi));

  a_r5_drive_needs_contest: assert property (@(posedge clk) disable iff (!rst_n)
    arb_drive |-> arb_busy && !vec_valid);
endmodule

bind irq_vector_unit irqv_checker #(.ID_W(ID_W), .DATA_W(DATA_W), .NLINES(NLINES)) chk (
  .clk(clk), .rst_n(rst_n), .req_a(req_a), .req_b(req_b),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq_lines(irq_lines),
  .arb_drive(arb_drive), .arb_line(arb_line), .vec_valid(vec_valid),
  .vec_data(vec_data), .arb_busy(arb_busy), .iack(iack),
  .arb_id(arb_id), .vec_hi(vec_hi)
);

// File: tb/irq_vector_unit_test.sv
`timescale 1ns/1ps
module irq_vector_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       req_a = 1'b0, req_b = 1'b0;
  logic [6:0] irq_lines;
  logic       iack = 1'b0;
  logic [2:0] iack_level = 3'd0, iack_mask = 3'd0;
  logic       arb_drive, arb_line, vec_valid;
  logic [7:0] vec_data;
  logic       rival_bit = 1'b0;
  int         n_checks = 0, n_fail = 0;
  logic [6:0] vreg = 7'h07;

  assign arb_line = arb_drive | rival_bit;

  always #2.5 clk = ~clk;

  irq_vector_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_a(req_a),
    .req_b(req_b), .irq_lines(irq_lines), .iack(iack),
    .iack_level(iack_level), .iack_mask(iack_mask), .arb_drive(arb_drive),
    .arb_line(arb_line), .vec_valid(vec_valid), .vec_data(vec_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  // Acknowledge one level; rival module contends with id rv.
  task automatic do_ack(input logic [2:0] la, input logic [2:0] lb, input logic ra,
                        input logic rb, input logic [2:0] lvl, input logic [2:0] msk,
                        input logic [3:0] id, input logic [3:0] rv, input string tag);
    logic pa, pb, contend, lost, r_act, exp_d;
    pa = ra && (la != 0) && (la == lvl);
    pb = rb && (lb != 0) && (lb == lvl);
    contend = (pa || pb) && ((lvl == 3'd7) || (lvl > msk)) && (id != 0);
    lost = 1'b0;
    r_act = (rv != 0);
    @(negedge clk);
    iack = 1'b1; iack_level = lvl; iack_mask = msk;
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      iack = 1'b0;
      if (j <= 4) begin
        int b;
        b = 4 - j;
        rival_bit = r_act && rv[b];
        #0.5;
        exp_d = contend && !lost && id[b];
        check({tag, " R7 drive bit"}, arb_drive, exp_d);
        check({tag, " R9 no early strobe"}, vec_valid, 1'b0);
        if (contend && !lost && !id[b] && rival_bit) lost = 1'b1;
        if (r_act && !rv[b] && exp_d) r_act = 1'b0;
      end else begin
        rival_bit = 1'b0;
        #0.5;
        if (j == 5) begin
          check({tag, " R9 strobe"}, vec_valid, contend && !lost);
          if (contend && !lost)
            check({tag, " R9/R10 vector"}, vec_data, {vreg, pa});
        end else begin
          check({tag, " R9 strobe one cycle"}, vec_valid, 1'b0);
        end
      end
    end
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    #1 check("R1 lines at reset", irq_lines, 7'd0);
    check("R1 drive at reset", arb_drive, 1'b0);
    check("R1 strobe at reset", vec_valid, 1'b0);
    rst_n = 1'b1;
    rd(2'd1, d); check("R1 vector reset", d, 8'h0F);
    rd(2'd0, d); check("R1 levels reset", d, 8'h00);
    rd(2'd2, d); check("R1 id reset", d, 8'h00);

    // R3: bit 0 ignored on write, reads 1
    wr(2'd1, 8'h40); rd(2'd1, d); check("R3 write even", d, 8'h41);
    wr(2'd1, 8'hA5); rd(2'd1, d); check("R3 write odd", d, 8'hA5);
    vreg = 7'h52;
    wr(2'd1, {vreg, 1'b0}); rd(2'd1, d); check("R3 vector", d, {vreg, 1'b1});
    // R2 layout
    wr(2'd0, 8'hFF); rd(2'd0, d); check("R2 level layout", d, 8'h77);
    wr(2'd2, 8'hFA); rd(2'd2, d); check("R2 id layout", d, 8'h0A);
    rd(2'd3, d); check("R2 unused offset", d, 8'h00);

    // Sweep levels, requests, ack levels and masks (R4 R5 R7 R9 R10)
    for (int la = 0; la < 8; la++) begin
      for (int lb = 0; lb < 8; lb++) begin
        wr(2'd0, {1'b0, 3'(la), 1'b0, 3'(lb)});
        for (int rq = 0; rq < 4; rq++) begin
          logic [6:0] exp_l;
          req_a = rq[1]; req_b = rq[0];
          exp_l = 7'd0;
          if (req_a && la != 0) exp_l[la-1] = 1'b1;
          if (req_b && lb != 0) exp_l[lb-1] = 1'b1;
          @(negedge clk); #0.5;
          check("R4 request lines", irq_lines, exp_l);
          for (int lv = 1; lv < 8; lv++) begin
            if (lv == la || lv == lb) begin
              do_ack(3'(la), 3'(lb), rq[1], rq[0], 3'(lv), 3'(lv - 1), 4'hA, 4'h0, "R5 above mask");
              do_ack(3'(la), 3'(lb), rq[1], rq[0], 3'(lv), 3'(lv), 4'hA, 4'h0, "R5 equal mask");
            end
          end
        end
      end
    end

    // ID contention sweep against a rival (R6 R7 R8 R9)
    wr(2'd0, 8'h35);
    req_a = 1'b1; req_b = 1'b1;
    for (int id = 0; id < 16; id++) begin
      wr(2'd2, 8'(id));
      for (int rv = 0; rv < 16; rv++)
        do_ack(3'd3, 3'd5, 1'b1, 1'b1, 3'd5, 3'd2, 4'(id), 4'(rv), "R8 contention");
    end
    wr(2'd2, 8'h00);
    do_ack(3'd3, 3'd5, 1'b1, 1'b1, 3'd3, 3'd0, 4'h0, 4'h0, "R6 zero id");
    // R10 tie at equal level, source A wins; level 7 unmaskable
    wr(2'd2, 8'h09);
    wr(2'd0, 8'h77);
    do_ack(3'd7, 3'd7, 1'b1, 1'b1, 3'd7, 3'd7, 4'h9, 4'h0, "R10 tie");
    req_a = 1'b0;
    do_ack(3'd7, 3'd7, 1'b0, 1'b1, 3'd7, 3'd7, 4'h9, 4'h0, "R10 B alone");
    req_b = 1'b0;
    @(negedge clk); #0.5 check("R4 request dropped", irq_lines, 7'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule